// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Controller

This block is a bus master for a three-wire serial EEPROM that stores 16-bit words. A host presents one request, a read or a write to an 8-bit word address, and then waits for a one-cycle completion pulse. A read returns the word that the device shifts out. A write reports an error flag when the device does not signal ready within the allowed window.

The controller drives chip select, serial clock and serial data toward the device, and it samples the device's data-out line. The serial clock is derived from the system clock by a fixed divider. Every serial clock level lasts `HALF_DIV` system clocks. A write is never a single frame. It is a chain of four steps with chip select released between them: unlock, data transfer, ready poll, and relock. The protect-enable pin stays low throughout.

Top module: `eeprom_word_ctrl`

## Requirements
- R1: After reset, cs_o, sk_o, di_o, busy and done are all low.
- R2: Every command frame clocks 11 bits, most significant first: a start bit of 1, a 2-bit opcode, then the 8-bit word address. The read opcode is 10, the write opcode is 01, and the unlock/relock opcode is 00.
- R3: The unlock frame carries 11000000 in its address field, so its full command is 100_11000000. The relock frame carries 00000000, so its full command is 100_00000000.
- R4: A read is one frame of 27 serial clocks. The 16 data bits follow the command, most significant first. Each bit is sampled one half-period after its rising SK edge and shifted in at the LSB. The word appears on rd_data when done pulses.
- R5: A write issues frames in this order, with CS dropped between each: unlock (11 clocks), write command plus 16 data bits (27 clocks), poll (0 data clocks), relock (11 clocks).
- R6: DI changes only while SK is low and stays stable while SK is high. DI is low and SK is low at the moment CS falls.
- R7: The ready poll holds CS high and samples DO every POLL_DIV clocks, at most POLL_MAX times. A high sample ends the poll, and the write finishes with wr_err = 0.
- R8: If all POLL_MAX samples read low, wr_err = 1 and the relock frame is still sent.
- R9: pre_o is low at all times.
- R10: busy rises the cycle after a request is accepted and falls in the cycle done pulses. done is high for exactly one cycle. A request raised while busy is high is ignored.
- R11: Every SK level lasts at least HALF_DIV system clocks. Inside a frame, successive rising SK edges are exactly 2*HALF_DIV clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Word to store on a write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Word returned by the last read |
| wr_err | output | 1 | Last write timed out waiting for ready |
| cs_o | output | 1 | Device chip select |
| sk_o | output | 1 | Serial clock |
| di_o | output | 1 | Serial data toward the device |
| do_i | input | 1 | Serial data from the device |
| pre_o | output | 1 | Protect enable, held low |

## Verification
A behavioural device model on the bench decodes every frame and logs it. Each of the 256 addresses is read back against an arithmetic word pattern, which separates address decoding errors from data bit-order errors. Writes to every second address, with all-zero, all-one and product patterns, are followed by read-back. This shows whether the unlock/write/poll/relock chain commits the right word. Three ready delays are used: immediate, just before the last poll sample, and just after it. These separate a correct poll limit from one sample too few or too many. A request raised during a busy read shows whether the controller ignores it.

// File: rtl/eewc_pkg.sv
// Shared types for the serial EEPROM word controller.
// Assumes a three-bit command head (start + 2-bit opcode) before the address.
package eewc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CSUP,
        ST_SKUP,
        ST_BITLO,
        ST_BITHI,
        ST_ENDLO,
        ST_CSDN,
        ST_SKHI,
        ST_POLL
    } eewc_state_e;

    typedef enum logic [2:0] {
        FK_READ,
        FK_UNLOCK,
        FK_WRITE,
        FK_POLL,
        FK_RELOCK
    } eewc_kind_e;

    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_MISC  = 2'b00;

endpackage

// File: rtl/eewc_tick.sv
// Half-period strobe generator for the serial clock.
// Counts DIV system clocks while enabled; restarts from zero when disabled.
module eewc_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CNT_W-1:0] cnt;

    assign tick = en && (cnt == CNT_W'(DIV - 1));

    // Advance the divider while enabled, wrap on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/eewc_poll_timer.sv
// Ready-poll pacing: strobes chk every INTERVAL clocks while enabled and
// flags the LIMIT-th strobe as last. Cleared whenever disabled.
module eewc_poll_timer #(
    parameter int INTERVAL = 20000,
    parameter int LIMIT    = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic chk,
    output logic last
);
    localparam int IW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam int LW = $clog2(LIMIT + 1);

    logic [IW-1:0] icnt;
    logic [LW-1:0] att;

    assign chk  = en && (icnt == IW'(INTERVAL - 1));
    assign last = (att == LW'(LIMIT - 1));

    // Interval counter between DO samples.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || chk) begin
            icnt <= '0;
        end else begin
            icnt <= icnt + 1'b1;
        end
    end

    // Number of samples already taken in this poll.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            att <= '0;
        end else if (chk) begin
            att <= att + 1'b1;
        end
    end
endmodule

// File: rtl/eewc_frame.sv
// Builds the left-justified bit string and clock count for one frame kind.
// Purely combinational; the sequencer loads it when a frame opens.
module eewc_frame
    import eewc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  eewc_kind_e                       kind,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [DATA_W-1:0]                wdata,
    output logic [3+ADDR_W+DATA_W-1:0]       bits,
    output logic [$clog2(3+ADDR_W+DATA_W+1)-1:0] nbits
);
    localparam int CMD_W   = 3 + ADDR_W;
    localparam int FRAME_W = CMD_W + DATA_W;
    localparam int CW      = $clog2(FRAME_W + 1);
    localparam logic [ADDR_W-1:0] UNLOCK_FIELD = {2'b11, {(ADDR_W-2){1'b0}}};

    // Select opcode, address field, payload and length per kind.
    always_comb begin
        bits  = '0;
        nbits = CW'(CMD_W);
        unique case (kind)
            FK_READ: begin
                bits  = {1'b1, OP_READ, addr, {DATA_W{1'b0}}};
                nbits = CW'(FRAME_W);
            end
            FK_WRITE: begin
                bits  = {1'b1, OP_WRITE, addr, wdata};
                nbits = CW'(FRAME_W);
            end
            FK_UNLOCK: bits = {1'b1, OP_MISC, UNLOCK_FIELD, {DATA_W{1'b0}}};
            FK_RELOCK: bits = {1'b1, OP_MISC, {ADDR_W{1'b0}}, {DATA_W{1'b0}}};
            default: begin
                bits  = '0;
                nbits = '0;
            end
        endcase
    end
endmodule

// File: rtl/eeprom_word_ctrl.sv
// Word-level master for a three-wire serial EEPROM.
// Accepts one read or write at a time, frames CS/SK/DI around each command,
// polls DO for write completion, and reports data or a timeout flag.
// Assumes HALF_DIV >= 2 system clocks per SK level and a synchronous DO.
module eeprom_word_ctrl
    import eewc_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int HALF_DIV = 4,
    parameter int POLL_DIV = 20000,
    parameter int POLL_MAX = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_err,
    output logic              cs_o,
    output logic              sk_o,
    output logic              di_o,
    input  logic              do_i,
    output logic              pre_o
);
    localparam int CMD_W   = 3 + ADDR_W;
    localparam int FRAME_W = CMD_W + DATA_W;
    localparam int CW      = $clog2(FRAME_W + 1);

    eewc_state_e         state;
    eewc_kind_e          kind_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [FRAME_W-1:0]  shreg;
    logic [CW-1:0]       bitcnt;
    logic                cap_pend;
    logic [FRAME_W-1:0]  frame_bits;
    logic [CW-1:0]       frame_nbits;
    logic                tick;
    logic                tick_en;
    logic                poll_chk;
    logic                poll_last;
    logic                is_in_bit;

    assign pre_o     = 1'b0;
    assign tick_en   = (state != ST_IDLE) && (state != ST_POLL);
    assign is_in_bit = (kind_q == FK_READ) && (bitcnt <= CW'(DATA_W));

    eewc_tick #(.DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (tick_en),
        .tick (tick)
    );

    eewc_poll_timer #(.INTERVAL(POLL_DIV), .LIMIT(POLL_MAX)) u_poll (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (state == ST_POLL),
        .chk  (poll_chk),
        .last (poll_last)
    );

    eewc_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .kind (kind_q),
        .addr (addr_q),
        .wdata(wdata_q),
        .bits (frame_bits),
        .nbits(frame_nbits)
    );

    // Sequencer: request intake, per-half-period pin steps, poll and chaining.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            kind_q   <= FK_READ;
            addr_q   <= '0;
            wdata_q  <= '0;
            shreg    <= '0;
            bitcnt   <= '0;
            cap_pend <= 1'b0;
            rd_data  <= '0;
            wr_err   <= 1'b0;
            busy     <= 1'b0;
            done     <= 1'b0;
            cs_o     <= 1'b0;
            sk_o     <= 1'b0;
            di_o     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        kind_q  <= req_write ? FK_UNLOCK : FK_READ;
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        wr_err  <= 1'b0;
                        busy    <= 1'b1;
                        state   <= ST_CSUP;
                    end
                end
                ST_CSUP: if (tick) begin
                    cs_o  <= 1'b1;
                    state <= ST_SKUP;
                end
                ST_SKUP: if (tick) begin
                    sk_o <= 1'b1;
                    if (kind_q == FK_POLL) begin
                        state <= ST_POLL;
                    end else begin
                        shreg  <= frame_bits;
                        bitcnt <= frame_nbits;
                        state  <= ST_BITLO;
                    end
                end
                ST_BITLO: if (tick) begin
                    if (cap_pend) rd_data <= {rd_data[DATA_W-2:0], do_i};
                    sk_o  <= 1'b0;
                    di_o  <= is_in_bit ? 1'b0 : shreg[FRAME_W-1];
                    state <= ST_BITHI;
                end
                ST_BITHI: if (tick) begin
                    sk_o     <= 1'b1;
                    cap_pend <= is_in_bit;
                    shreg    <= shreg << 1;
                    bitcnt   <= bitcnt - 1'b1;
                    state    <= (bitcnt == CW'(1)) ? ST_ENDLO : ST_BITLO;
                end
                ST_POLL: if (poll_chk) begin
                    if (do_i) begin
                        state <= ST_ENDLO;
                    end else if (poll_last) begin
                        wr_err <= 1'b1;
                        state  <= ST_ENDLO;
                    end
                end
                ST_ENDLO: if (tick) begin
                    if (cap_pend) rd_data <= {rd_data[DATA_W-2:0], do_i};
                    cap_pend <= 1'b0;
                    sk_o     <= 1'b0;
                    di_o     <= 1'b0;
                    state    <= ST_CSDN;
                end
                ST_CSDN: if (tick) begin
                    cs_o  <= 1'b0;
                    state <= ST_SKHI;
                end
                ST_SKHI: if (tick) begin
                    sk_o <= 1'b1;
                    unique case (kind_q)
                        FK_UNLOCK: begin kind_q <= FK_WRITE;  state <= ST_CSUP; end
                        FK_WRITE:  begin kind_q <= FK_POLL;   state <= ST_CSUP; end
                        FK_POLL:   begin kind_q <= FK_RELOCK; state <= ST_CSUP; end
                        default: begin
                            busy  <= 1'b0;
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end
                    endcase
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/eewc_checker.sv
// Protocol checker for eeprom_word_ctrl, attached by bind below.
// Observes pins and handshake only; keeps its own SK level-length counter.
module eewc_checker #(
    parameter int HALF_DIV = 4
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic cs_o,
    input logic sk_o,
    input logic di_o
);
    logic        sk_q;
    logic [15:0] sk_run;

    // Track how many clocks the current SK level has lasted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sk_q   <= 1'b0;
            sk_run <= '0;
        end else begin
            sk_q <= sk_o;
            if (sk_o != sk_q)        sk_run <= 16'd1;
            else if (sk_run != 16'hFFFF) sk_run <= sk_run + 1'b1;
        end
    end

    assert_di_moves_sklow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(di_o) |-> !sk_o);

    assert_cs_drops_sklow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_o) |-> (!sk_o && !di_o));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_ends_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    assert_sk_half_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sk_o != sk_q) |-> (sk_run >= 16'(HALF_DIV)));
endmodule

bind eeprom_word_ctrl eewc_checker #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .busy     (busy),
    .done     (done),
    .cs_o     (cs_o),
    .sk_o     (sk_o),
    .di_o     (di_o)
);

// File: tb/sim_eeprom_word_ctrl.sv
`timescale 1ns/1ps
module sim_eeprom_word_ctrl;
    localparam int HALF = 2;
    localparam int PDIV = 8;
    localparam int PMAX = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, wr_err, cs_o, sk_o, di_o, pre_o;
    logic [15:0] rd_data;
    logic        do_i;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    eeprom_word_ctrl #(
        .ADDR_W(8), .DATA_W(16), .HALF_DIV(HALF), .POLL_DIV(PDIV), .POLL_MAX(PMAX)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .wr_err(wr_err), .cs_o(cs_o), .sk_o(sk_o),
        .di_o(di_o), .do_i(do_i), .pre_o(pre_o)
    );

    function automatic logic [15:0] seed_word(input int a);
        return {a[7:0], ~a[7:0]} ^ 16'h3C5A;
    endfunction

    // ---------------- device model ----------------
    logic [15:0] mem [256];
    logic [10:0] flog_cmd [16];
    int          flog_nb [16];
    int          fcount = 0;
    int          ready_delay = 0;
    int          frame_viol = 0;
    int          pre_viol = 0;
    int          gap_min = 1000;
    logic        cs_p = 0, sk_p = 0, di_p = 0;
    logic        started = 0, wen = 0, wr_busy = 0, in_poll = 0;
    logic [10:0] cmd = '0;
    logic [15:0] wd = '0;
    int          nb = 0, gap = 0, pcnt = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] = seed_word(i);
            do_i <= 1'b0;
        end else begin
            if (cs_o && !cs_p) begin
                nb = 0; started = 0; cmd = '0; wd = '0; gap = 0;
                if (wr_busy) begin in_poll = 1; pcnt = 0; end
            end
            if (cs_o) gap = gap + 1;
            if (cs_o && sk_o && !sk_p) begin
                if (started && gap < gap_min) gap_min = gap;
                gap = 0;
                if (!started && di_o) started = 1;
                if (started) begin
                    nb = nb + 1;
                    if (nb <= 11) cmd = {cmd[9:0], di_o};
                    else wd = {wd[14:0], di_o};
                    if (nb >= 12 && nb <= 27 && cmd[10:8] == 3'b110)
                        do_i <= mem[cmd[7:0]][27 - nb];
                end
            end
            if (in_poll && cs_o) begin
                pcnt = pcnt + 1;
                do_i <= (pcnt >= ready_delay);
            end
            if (cs_o && sk_o && sk_p && (di_o != di_p)) frame_viol++;
            if (!cs_o && cs_p) begin
                if (sk_o || di_o) frame_viol++;
                flog_cmd[fcount % 16] = cmd;
                flog_nb[fcount % 16]  = nb;
                fcount = fcount + 1;
                do_i <= 1'b0;
                if (in_poll) begin
                    in_poll = 0; wr_busy = 0;
                end else if (nb == 27 && cmd[10:8] == 3'b101 && wen) begin
                    mem[cmd[7:0]] = wd; wr_busy = 1;
                end else if (nb == 11 && cmd[10:8] == 3'b100) begin
                    wen = (cmd[7:6] == 2'b11);
                end
            end
            if (pre_o) pre_viol++;
            cs_p = cs_o; sk_p = sk_o; di_p = di_o;
        end
    end

    // ---------------- checking helpers ----------------
    logic [15:0] exp_w [256];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic [15:0] got_rd;
    logic        got_err;
    int          base;

    task automatic run_op(input logic wr, input logic [7:0] a, input logic [15:0] d,
                          input bit poke);
        base = fcount;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            check(busy == 1'b1, "R10 busy after accept", busy, 1);
            repeat (10) @(negedge clk);
            req_valid = 1'b1; req_write = 1'b1; req_addr = a ^ 8'h01; req_wdata = 16'hDEAD;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        got_rd = rd_data;
        got_err = wr_err;
        check(busy == 1'b0, "R10 busy low at done", busy, 0);
        @(negedge clk);
        check(done == 1'b0, "R10 done one cycle", done, 0);
    endtask

    task automatic check_write_frames(input logic [7:0] a);
        check(fcount - base == 4, "R5 write frame count", fcount - base, 4);
        check(flog_nb[base % 16] == 11 && flog_cmd[base % 16] == 11'h4C0,
              "R3 unlock frame", flog_cmd[base % 16], 11'h4C0);
        check(flog_nb[(base + 1) % 16] == 27 && flog_cmd[(base + 1) % 16] == {3'b101, a},
              "R5 write frame", flog_cmd[(base + 1) % 16], {3'b101, a});
        check(flog_nb[(base + 2) % 16] == 0, "R5 poll frame clocks", flog_nb[(base + 2) % 16], 0);
        check(flog_nb[(base + 3) % 16] == 11 && flog_cmd[(base + 3) % 16] == 11'h400,
              "R3 relock frame", flog_cmd[(base + 3) % 16], 11'h400);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        for (int i = 0; i < 256; i++) exp_w[i] = seed_word(i);
        repeat (4) @(negedge clk);
        check({cs_o, sk_o, di_o, busy, done} == 5'b0, "R1 reset outputs",
              {cs_o, sk_o, di_o, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({cs_o, sk_o, di_o, busy, done} == 5'b0, "R1 idle after reset",
              {cs_o, sk_o, di_o, busy, done}, 0);

        // R4 / R2: read sweep over every address
        for (int a = 0; a < 256; a++) begin
            run_op(1'b0, 8'(a), 16'h0, 1'b0);
            check(got_rd == exp_w[a], "R4 read data", got_rd, exp_w[a]);
            check(fcount - base == 1 && flog_nb[base % 16] == 27 &&
                  flog_cmd[base % 16] == {3'b110, 8'(a)}, "R2 read command",
                  flog_cmd[base % 16], {3'b110, 8'(a)});
        end
        check(gap_min == 2 * HALF, "R11 SK period", gap_min, 2 * HALF);

        // R5 / R7: writes with immediate ready, then read back
        ready_delay = 0;
        for (int a = 0; a < 256; a += 2) begin
            logic [15:0] d;
            d = (a == 0) ? 16'h0000 : (a == 2) ? 16'hFFFF : 16'(a * 16'h9E37) ^ 16'h5A5A;
            run_op(1'b1, 8'(a), d, 1'b0);
            exp_w[a] = d;
            check(got_err == 1'b0, "R7 ready immediate", got_err, 0);
            check_write_frames(8'(a));
            run_op(1'b0, 8'(a), 16'h0, 1'b0);
            check(got_rd == d, "R5 write read-back", got_rd, d);
        end

        // R7: ready appears just before the final poll sample
        ready_delay = 37;
        run_op(1'b1, 8'h11, 16'h1234, 1'b0);
        exp_w[8'h11] = 16'h1234;
        check(got_err == 1'b0, "R7 ready at last sample", got_err, 0);
        check_write_frames(8'h11);

        // R8: ready appears just after the final poll sample
        ready_delay = 45;
        run_op(1'b1, 8'h21, 16'hBEEF, 1'b0);
        exp_w[8'h21] = 16'hBEEF;
        check(got_err == 1'b1, "R8 ready too late", got_err, 1);
        check_write_frames(8'h21);

        // R8: never ready
        ready_delay = 100000;
        run_op(1'b1, 8'h33, 16'hC0DE, 1'b0);
        exp_w[8'h33] = 16'hC0DE;
        check(got_err == 1'b1, "R8 never ready", got_err, 1);
        check(flog_cmd[(base + 3) % 16] == 11'h400, "R8 relock still sent",
              flog_cmd[(base + 3) % 16], 11'h400);

        // R10: request during busy read is ignored
        ready_delay = 0;
        run_op(1'b0, 8'h04, 16'h0, 1'b1);
        check(got_rd == exp_w[8'h04], "R10 read with poke", got_rd, exp_w[8'h04]);
        check(fcount - base == 1, "R10 poke adds no frame", fcount - base, 1);
        run_op(1'b0, 8'h05, 16'h0, 1'b0);
        check(got_rd == exp_w[8'h05], "R10 poked address untouched", got_rd, exp_w[8'h05]);

        check(frame_viol == 0, "R6 DI/SK/CS framing", frame_viol, 0);
        check(pre_viol == 0, "R9 protect pin low", pre_viol, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule